// File: doc/BRIEF.md
# Parallel I/O Line Controller with Input Filter

This block owns a bank of bidirectional I/O lines (32 by default). Each line is either handed to a peripheral function or kept by the controller. A line the controller keeps takes its output level and drive enable from controller registers. A line handed to a peripheral passes that peripheral's output and enable through unchanged. After reset the controller keeps every line, so nothing drives a pad until software chooses to.

The input level of every line is sampled into the clock domain. Each line can switch in a two-sample glitch filter. A line can also report a change of its effective input level. Changes are latched per line in a change register that clears when read. A single interrupt output is the OR of the latched changes whose interrupt enable is set.

Configuration uses a small word-addressed bus. Every configuration register has three addresses: a set address, a clear address and a value address. Software can therefore change single bits without a read-modify-write sequence.

Top module: `pio_ctrl`

## Requirements
- R1: After synchronous reset, the ownership register is all ones and the output-enable, output-data, filter-enable and interrupt-enable registers are zero. The change register is zero, irq is 0, and pad_out and pad_oe are 0 on every line.
- R2: The address is split into a group field, addr[4:2], and an operation field, addr[1:0]. The groups are ownership 0, output enable 1, filter enable 2, output data 3 and interrupt enable 4. A write to operation 0 (set) makes every bit that is 1 in wdata a 1. Bits that are 0 in wdata keep their value.
- R3: A write to operation 1 (clear) makes every bit that is 1 in wdata a 0, and leaves the bits that are 0 in wdata unchanged. A write to operation 2 (value) changes nothing.
- R4: Where the ownership bit is 1, pad_out and pad_oe follow the output-data and output-enable registers. Where it is 0, they follow per_out and per_oe. This path is combinational.
- R5: A read of address 20 returns the sampled raw pad levels. pad_in is sampled once per clock, whatever the ownership.
- R6: With its filter bit set, a line's effective input takes a new level only after two consecutive samples agree on it. A one-cycle pulse is dropped. per_in carries the effective input of every line.
- R7: Any change of a line's effective input sets that line's bit in the change register, which is read at address 21.
- R8: A read of address 21 clears the change register. A change detected on the clock edge of that read is kept for the next read.
- R9: irq is 1 exactly when some latched change bit has its interrupt-enable bit set. Masked changes are still latched.
- R10: Reads return data one clock after rd_en. A read of a value address returns that register. A read of a set, clear or unused address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Word address: group in [4:2], operation in [1:0] |
| wdata | input | NPIN | Write data |
| rdata | output | NPIN | Read data, registered |
| pad_in | input | NPIN | Pad input levels |
| pad_out | output | NPIN | Pad output levels |
| pad_oe | output | NPIN | Pad drive enables |
| per_out | input | NPIN | Peripheral output levels |
| per_oe | input | NPIN | Peripheral drive enables |
| per_in | output | NPIN | Effective (optionally filtered) input levels |
| irq | output | 1 | Combined change interrupt |

## Verification
The results fall due at different times:

| Result | Due |
|---|---|
| Pad output mux | At once |
| Register write | Visible at the edge that takes it |
| Read data | At the edge that samples rd_en |
| Pin data readback | One edge after the pad change |
| Change bit and irq, unfiltered line | Two edges after the pad change |
| per_in, filtered line | Three edges after the pad change |
| Change bit and irq, filtered line | Four edges after the pad change |

The bench drives inputs and samples outputs one time unit after a rising edge. It counts edges explicitly before each comparison. It also checks a point one edge too early on the filtered path, which proves that the level is still held there.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int ADDR_W  = 5;
    localparam int NUM_CFG = 5;

    // Group field addr[4:2]
    typedef enum logic [2:0] {
        GRP_OWN  = 3'd0,
        GRP_OE   = 3'd1,
        GRP_FLT  = 3'd2,
        GRP_ODAT = 3'd3,
        GRP_IEN  = 3'd4,
        GRP_STAT = 3'd5,
        GRP_RSV6 = 3'd6,
        GRP_RSV7 = 3'd7
    } grp_e;

    // Operation field addr[1:0]
    typedef enum logic [1:0] {
        OP_SET = 2'd0,
        OP_CLR = 2'd1,
        OP_VAL = 2'd2,
        OP_RSV = 2'd3
    } op_e;

    typedef struct packed {
        grp_e grp;
        op_e  op;
    } acc_t;

    localparam logic [ADDR_W-1:0] A_PIN = 5'd20;
    localparam logic [ADDR_W-1:0] A_CHG = 5'd21;

    function automatic acc_t split_addr(input logic [ADDR_W-1:0] a);
        acc_t r;
        r.grp = grp_e'(a[4:2]);
        r.op  = op_e'(a[1:0]);
        return r;
    endfunction

endpackage

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [NPIN-1:0]                wdata,
    output logic [NUM_CFG-1:0][NPIN-1:0]   cfg_q
);

    acc_t acc;
    assign acc = split_addr(addr);

    // R2/R3: one set/clear/value triple per configuration group
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_grp
        localparam logic [NPIN-1:0] RST_VAL = (g == int'(GRP_OWN)) ? '1 : '0;
        logic [NPIN-1:0] r;
        logic            hit;

        assign hit = wr_en && (int'(acc.grp) == g);

        always_ff @(posedge clk) begin
            if (rst) begin
                r <= RST_VAL;
            end else if (hit) begin
                case (acc.op)
                    OP_SET:  r <= r | wdata;
                    OP_CLR:  r <= r & ~wdata;
                    default: r <= r;
                endcase
            end
        end

        assign cfg_q[g] = r;
    end

endmodule

// File: rtl/pio_infilt.sv
module pio_infilt #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pad_in,
    input  logic [NPIN-1:0] flt_en,
    output logic [NPIN-1:0] s1,
    output logic [NPIN-1:0] s2,
    output logic [NPIN-1:0] flt,
    output logic [NPIN-1:0] eff
);

    // R6: per-line sampler and two-sample agreement filter
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic s1_r, s2_r, flt_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1_r  <= 1'b0;
                s2_r  <= 1'b0;
                flt_r <= 1'b0;
            end else begin
                s1_r <= pad_in[i];
                s2_r <= s1_r;
                if (s1_r == s2_r) begin
                    flt_r <= s1_r;
                end
            end
        end

        assign s1[i]  = s1_r;
        assign s2[i]  = s2_r;
        assign flt[i] = flt_r;
        assign eff[i] = flt_en[i] ? flt_r : s1_r;
    end

endmodule

// File: rtl/pio_chg.sv
module pio_chg #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] eff,
    input  logic            rd_clr,
    output logic [NPIN-1:0] chg_q
);

    logic [NPIN-1:0] last_q;
    logic [NPIN-1:0] edge_now;

    assign edge_now = eff ^ last_q;

    // R7/R8: latch changes, clear on read, keep a change that lands with the read
    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            chg_q  <= '0;
        end else begin
            last_q <= eff;
            chg_q  <= (rd_clr ? '0 : chg_q) | edge_now;
        end
    end

endmodule

// File: rtl/pio_padmux.sv
module pio_padmux #(
    parameter int NPIN = 32
) (
    input  logic [NPIN-1:0] own,
    input  logic [NPIN-1:0] odat,
    input  logic [NPIN-1:0] oe,
    input  logic [NPIN-1:0] per_out,
    input  logic [NPIN-1:0] per_oe,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe
);

    // R4: per-line ownership select
    for (genvar i = 0; i < NPIN; i++) begin : g_mux
        assign pad_out[i] = own[i] ? odat[i] : per_out[i];
        assign pad_oe[i]  = own[i] ? oe[i]   : per_oe[i];
    end

endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
    import pio_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NPIN-1:0]      wdata,
    output logic [NPIN-1:0]      rdata,
    input  logic [NPIN-1:0]      pad_in,
    output logic [NPIN-1:0]      pad_out,
    output logic [NPIN-1:0]      pad_oe,
    input  logic [NPIN-1:0]      per_out,
    input  logic [NPIN-1:0]      per_oe,
    output logic [NPIN-1:0]      per_in,
    output logic                 irq
);

    logic [NUM_CFG-1:0][NPIN-1:0] cfg_q;
    logic [NPIN-1:0] own_q, oe_q, flt_en_q, odat_q, ien_q;
    logic [NPIN-1:0] s1, s2, flt, eff, chg_q, rd_val, rdata_q;
    logic            rd_clr;
    acc_t            acc;

    pio_regs #(.NPIN(NPIN)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .cfg_q(cfg_q)
    );

    assign own_q    = cfg_q[GRP_OWN];
    assign oe_q     = cfg_q[GRP_OE];
    assign flt_en_q = cfg_q[GRP_FLT];
    assign odat_q   = cfg_q[GRP_ODAT];
    assign ien_q    = cfg_q[GRP_IEN];

    pio_infilt #(.NPIN(NPIN)) u_infilt (
        .clk(clk), .rst(rst), .pad_in(pad_in), .flt_en(flt_en_q),
        .s1(s1), .s2(s2), .flt(flt), .eff(eff)
    );

    assign rd_clr = rd_en && (addr == A_CHG);

    pio_chg #(.NPIN(NPIN)) u_chg (
        .clk(clk), .rst(rst), .eff(eff), .rd_clr(rd_clr), .chg_q(chg_q)
    );

    pio_padmux #(.NPIN(NPIN)) u_mux (
        .own(own_q), .odat(odat_q), .oe(oe_q),
        .per_out(per_out), .per_oe(per_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // R10: read decode
    assign acc = split_addr(addr);

    always_comb begin
        rd_val = '0;
        if (acc.op == OP_VAL) begin
            case (acc.grp)
                GRP_OWN:  rd_val = own_q;
                GRP_OE:   rd_val = oe_q;
                GRP_FLT:  rd_val = flt_en_q;
                GRP_ODAT: rd_val = odat_q;
                GRP_IEN:  rd_val = ien_q;
                default:  rd_val = '0;
            endcase
        end else if (addr == A_PIN) begin
            rd_val = s1;
        end else if (addr == A_CHG) begin
            rd_val = chg_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_val;
        end
    end

    assign rdata  = rdata_q;
    assign per_in = eff;
    assign irq    = |(chg_q & ien_q);   // R9

endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk
    import pio_pkg::*;
#(
    parameter int NPIN = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [NPIN-1:0]   wdata,
    input logic [NPIN-1:0]   rdata,
    input logic              irq,
    input logic [NPIN-1:0]   own_q,
    input logic [NPIN-1:0]   ien_q,
    input logic [NPIN-1:0]   chg_q,
    input logic [NPIN-1:0]   s1,
    input logic [NPIN-1:0]   s2,
    input logic [NPIN-1:0]   flt
);

    a_r1_irq_low_after_reset: assert property (@(posedge clk)
        rst |=> !irq);

    a_r1_owned_after_reset: assert property (@(posedge clk)
        rst |=> (own_q == '1));

    a_r2_set_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 5'd0) |=> ((own_q & $past(wdata)) == $past(wdata)));

    a_r3_clear_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 5'd1) |=> ((own_q & $past(wdata)) == '0));

    a_r6_filter_needs_agreement: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((flt ^ $past(flt)) & ($past(s1) ^ $past(s2))) == '0));

    a_r8_read_returns_changes: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_CHG) |=> (rdata == $past(chg_q)));

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq);

endmodule

bind pio_ctrl pio_ctrl_chk #(.NPIN(NPIN)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .own_q(own_q),
    .ien_q(ien_q), .chg_q(chg_q), .s1(s1), .s2(s2), .flt(flt)
);

// File: tb/test_pio_ctrl.sv
`timescale 1ns/1ps
module test_pio_ctrl;

    localparam int NPIN = 32;
    localparam int NV   = 10;

    // {write addr, write data, read addr, expected}
    localparam logic [73:0] VEC [NV] = '{
        {5'd4,  32'h0000_00FF, 5'd6,  32'h0000_00FF},
        {5'd4,  32'h0000_0000, 5'd6,  32'h0000_00FF},
        {5'd5,  32'h0000_000F, 5'd6,  32'h0000_00F0},
        {5'd5,  32'h0000_0000, 5'd6,  32'h0000_00F0},
        {5'd6,  32'hFFFF_FFFF, 5'd6,  32'h0000_00F0},
        {5'd12, 32'hA5A5_0000, 5'd14, 32'hA5A5_0000},
        {5'd1,  32'h0000_FFFF, 5'd2,  32'hFFFF_0000},
        {5'd8,  32'h8000_0001, 5'd10, 32'h8000_0001},
        {5'd16, 32'h0000_0003, 5'd18, 32'h0000_0003},
        {5'd31, 32'hFFFF_FFFF, 5'd31, 32'h0000_0000}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]      addr = '0;
    logic [NPIN-1:0] wdata = '0, pad_in = '0, per_out = '0, per_oe = '0;
    logic [NPIN-1:0] rdata, pad_out, pad_oe, per_in;
    logic            irq;

    int total = 0;
    int fails = 0;
    logic [NPIN-1:0] d;

    always #2.5 clk = ~clk;

    pio_ctrl #(.NPIN(NPIN)) i_pio_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .per_out(per_out), .per_oe(per_oe),
        .per_in(per_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [NPIN-1:0] act, input logic [NPIN-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [NPIN-1:0] v);
        addr = a; wdata = v; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [NPIN-1:0] v);
        addr = a; rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        v = rdata;
    endtask

    function automatic string vtag(input int i);
        if (i == NV - 1) return "R10 unused address";
        if (i >= 2 && i <= 4) return "R3 clear/value write";
        return "R2 set write";
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        chk("R1 pad_out", pad_out, '0);
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 irq", {31'd0, irq}, '0);
        rd(5'd2, d);  chk("R1 ownership", d, '1);
        rd(5'd6, d);  chk("R1 output enable", d, '0);
        rd(5'd21, d); chk("R1 change register", d, '0);

        // Table walk: R2, R3, R10
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][73:69], VEC[i][68:37]);
            rd(VEC[i][36:32], d);
            chk(vtag(i), d, VEC[i][31:0]);
        end
        rd(5'd4, d); chk("R10 set address reads zero", d, '0);

        // R4 ownership mux: own = FFFF0000, oe = F0, odat = A5A50000
        per_out = 32'h1234_5678;
        per_oe  = 32'h0000_ABCD;
        #1;
        chk("R4 pad_out", pad_out, 32'hA5A5_5678);
        chk("R4 pad_oe", pad_oe, 32'h0000_ABCD);

        // R5 / R7 unfiltered bit 4 (interrupt masked)
        pad_in = 32'h0000_0010;
        tick();
        rd(5'd20, d); chk("R5 pin data", d, 32'h0000_0010);
        rd(5'd21, d); chk("R7 change latched", d, 32'h0000_0010);
        chk("R9 masked change no irq", {31'd0, irq}, '0);
        rd(5'd21, d); chk("R8 cleared after read", d, '0);

        // R9 enabled bit 1
        pad_in = 32'h0000_0012;
        tick();
        tick();
        chk("R9 irq raised", {31'd0, irq}, 32'd1);
        rd(5'd21, d); chk("R9 change bit", d, 32'h0000_0002);
        chk("R9 irq dropped after clear", {31'd0, irq}, '0);

        // R8 change landing on the read edge is kept
        pad_in = 32'h0000_0032;
        tick();
        rd(5'd21, d); chk("R8 read before change", d, '0);
        rd(5'd21, d); chk("R8 change kept", d, 32'h0000_0020);

        // R6 filtered bit 0: one-cycle pulse dropped
        pad_in = 32'h0000_0033;
        tick();
        pad_in = 32'h0000_0032;
        tick();
        tick();
        tick();
        chk("R6 pulse dropped per_in", per_in, 32'h0000_0032);
        rd(5'd21, d); chk("R6 pulse no change", d, '0);

        // R6 steady level passes after two agreeing samples
        pad_in = 32'h0000_0033;
        tick();
        tick();
        chk("R6 not yet passed", per_in & 32'h1, '0);
        tick();
        chk("R6 passed", per_in & 32'h1, 32'h1);
        tick();
        chk("R9 filtered change irq", {31'd0, irq}, 32'd1);
        rd(5'd21, d); chk("R7 filtered change bit", d, 32'h0000_0001);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule